// File: doc/BRIEF.md
# Iterative Radix-2 Step Divider

This block is an unsigned 64-bit divider that a sequencer drives through two commands. A LOAD command clears the quotient, puts a source word into the partial remainder and stores the divisor. It then makes one aligned subtraction. The divisor is shifted so that its leading one sits under the leading one of the partial dividend. If the shifted divisor is too large, it backs off by one position. The divisor is subtracted once and the matching quotient bit is added.

A STEP command carries a source word and a count of dividend bits still to be consumed. While the partial remainder is below the divisor and the count is nonzero, the block pulls in one bit per clock. The bit is taken from the source word at index count−1. On each such clock the quotient shifts left and the count drops by one. The STEP then ends with one aligned subtraction and returns the updated count. An optional zero flag can mark that the count has run out.

A full 64-by-64 division is one LOAD with a zero source word, followed by STEP commands with the dividend as source. Each STEP takes the count returned by the previous one, and the sequence stops when the returned count is zero. A STEP with a count of zero changes nothing, so an unrolled sequence may run past the end safely.

Top module: `stepdiv`

## Requirements
- R1: After reset, busy, done, div_err, zero_flag, cnt_out, quotient and remainder are all zero.
- R2: A LOAD command (cmd_op=0) with a nonzero divisor sets quotient to 0, remainder to src_word and stores div_in, then makes one aligned subtraction. Done rises one cycle after acceptance with div_err low, and cnt_out and zero_flag are unchanged.
- R3: When the divisor exceeds the partial dividend, the aligned subtraction leaves quotient and remainder unchanged (LOAD 7 by 100 gives quotient 0, remainder 7).
- R4: The aligned subtraction shifts the divisor by the difference of the two leading-one positions. It backs off by one position if the shifted divisor then exceeds the dividend, and adds the quotient bit of that position. LOAD 100 by 3 gives 32 rem 4, and LOAD 100 by 7 gives 8 rem 44.
- R5: A LOAD with a zero divisor raises div_err with done and leaves quotient and remainder unchanged.
- R6: A STEP command (cmd_op=1) with cnt_in=0 finishes one cycle after acceptance, with quotient and remainder unchanged and cnt_out=0.
- R7: A STEP with nonzero count and a stored divisor pulls in one source bit per clock, taking bit index count−1. Done rises k+2 cycles after acceptance, where k is the number of bits pulled in.
- R8: A STEP stops pulling bits as soon as the partial remainder reaches the divisor, and reports the remaining count on cnt_out (divisor 1, source bit 63 set, count 64 returns 63).
- R9: On STEP completion, when cmd_zf_en was high at acceptance, zero_flag becomes 1 if the returned count is zero and 0 otherwise. When cmd_zf_en was low, zero_flag keeps its value.
- R10: While busy is high, commands are ignored, and busy and done are never high together.
- R11: LOAD with source 0 and divisor d, followed by repeated STEPs with source n that feed back cnt_out until it reaches zero (first count 64), leaves quotient n/d and remainder n%d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_op | input | 1 | 0 = LOAD, 1 = STEP |
| cmd_zf_en | input | 1 | STEP updates zero_flag when high |
| src_word | input | 64 | LOAD: initial dividend; STEP: word supplying low dividend bits |
| div_in | input | 64 | LOAD: divisor to store |
| cnt_in | input | 7 | STEP: dividend bits still to pull in (0 to 64) |
| busy | output | 1 | A STEP is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| div_err | output | 1 | Last completed command met a zero divisor |
| zero_flag | output | 1 | Returned count reached zero |
| cnt_out | output | 7 | Updated remaining count from the last STEP |
| quotient | output | 64 | Quotient state |
| remainder | output | 64 | Remainder state |

## Verification
LOAD results, zero-count STEP results and error results are due on the clock edge after acceptance. A STEP that pulls in k bits is due k+2 edges after acceptance. The bench drives each command at a falling edge, counts rising edges until done is seen at a later falling edge, and compares that count with the expected latency where the latency is known. All result values are sampled in the same falling-edge window where done is first observed.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
  typedef enum logic {
    OP_LOAD = 1'b0,
    OP_STEP = 1'b1
  } sd_op_e;
endpackage

// File: rtl/stepdiv_lead.sv
// Leading-one position of a vector (zero when the vector is zero).
module stepdiv_lead #(
  parameter int N  = 65,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) pos = i[LW-1:0];
    end
  end
endmodule

// File: rtl/stepdiv_align.sv
// One aligned subtraction: shift divisor under the dividend's leading one,
// back off by one if too large, subtract once.
module stepdiv_align #(
  parameter int N = 65,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0] num,
  input  logic [N-1:0] den,
  output logic [N-1:0] qbit,
  output logic [N-1:0] diff
);
  logic [LW-1:0] pos_num, pos_den, shamt;
  logic [N-1:0]  den_sh, qb_sh;
  logic          hit;

  stepdiv_lead #(.N(N)) u_lead_num (.vec(num), .pos(pos_num));
  stepdiv_lead #(.N(N)) u_lead_den (.vec(den), .pos(pos_den));

  always_comb begin
    hit    = (den != '0) && (den <= num);
    shamt  = pos_num - pos_den;
    den_sh = den << shamt;
    qb_sh  = {{(N-1){1'b0}}, 1'b1} << shamt;
    if (den_sh > num) begin
      den_sh = den_sh >> 1;
      qb_sh  = qb_sh >> 1;
    end
    if (hit) begin
      qbit = qb_sh;
      diff = num - den_sh;
    end else begin
      qbit = '0;
      diff = num;
    end
  end
endmodule

// File: rtl/stepdiv.sv
module stepdiv
  import stepdiv_pkg::*;
#(
  parameter int W = 64,
  localparam int N  = W + 1,
  localparam int CW = $clog2(W + 1),
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic          cmd_zf_en,
  input  logic [W-1:0]  src_word,
  input  logic [W-1:0]  div_in,
  input  logic [CW-1:0] cnt_in,
  output logic          busy,
  output logic          done,
  output logic          div_err,
  output logic          zero_flag,
  output logic [CW-1:0] cnt_out,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder
);
  localparam logic [CW-1:0] CNT_ONE = 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic [W-1:0]  q_q, q_nx, d_q, d_nx, src_q, src_nx;
  logic [N-1:0]  r_q, r_nx;
  logic [CW-1:0] cnt_q, cnt_nx, bit_sel;
  logic          busy_q, busy_nx, done_q, done_nx, err_q, err_nx;
  logic          zf_q, zf_nx, zfen_q, zfen_nx;
  logic          accept, en;
  logic [N-1:0]  al_num, al_den, al_qbit, al_diff;

  assign accept  = cmd_valid && !busy_q;
  assign bit_sel = cnt_q - CNT_ONE;

  // one shared aligner: command operands at LOAD, state while stepping
  always_comb begin
    if (busy_q) begin
      al_num = r_q;
      al_den = {1'b0, d_q};
    end else begin
      al_num = {1'b0, src_word};
      al_den = {1'b0, div_in};
    end
  end

  stepdiv_align #(.N(N)) u_align (
    .num(al_num), .den(al_den), .qbit(al_qbit), .diff(al_diff)
  );

  always_comb begin
    q_nx = q_q;  r_nx = r_q;  d_nx = d_q;  src_nx = src_q;
    cnt_nx = cnt_q;  busy_nx = busy_q;  done_nx = 1'b0;
    err_nx = err_q;  zf_nx = zf_q;  zfen_nx = zfen_q;
    if (accept) begin
      if (cmd_op == OP_LOAD) begin
        done_nx = 1'b1;
        if (div_in == '0) begin
          err_nx = 1'b1;
        end else begin
          err_nx = 1'b0;
          d_nx   = div_in;
          q_nx   = al_qbit[W-1:0];
          r_nx   = al_diff;
        end
      end else if (cnt_in == '0) begin
        done_nx = 1'b1;
        err_nx  = 1'b0;
        cnt_nx  = '0;
        if (cmd_zf_en) zf_nx = 1'b1;
      end else if (d_q == '0) begin
        done_nx = 1'b1;
        err_nx  = 1'b1;
        cnt_nx  = cnt_in;
        if (cmd_zf_en) zf_nx = 1'b0;
      end else begin
        busy_nx = 1'b1;
        cnt_nx  = cnt_in;
        src_nx  = src_word;
        zfen_nx = cmd_zf_en;
      end
    end else if (busy_q) begin
      if ((r_q < {1'b0, d_q}) && (cnt_q != '0)) begin
        r_nx   = {r_q[W-1:0], src_q[bit_sel[IW-1:0]]};
        q_nx   = {q_q[W-2:0], 1'b0};
        cnt_nx = bit_sel;
      end else begin
        q_nx    = q_q + al_qbit[W-1:0];
        r_nx    = al_diff;
        busy_nx = 1'b0;
        done_nx = 1'b1;
        err_nx  = 1'b0;
        if (zfen_q) zf_nx = (cnt_q == '0);
      end
    end
  end

  assign en = accept || busy_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      q_q <= '0;  r_q <= '0;  d_q <= '0;  src_q <= '0;  cnt_q <= '0;
      busy_q <= 1'b0;  done_q <= 1'b0;  err_q <= 1'b0;
      zf_q <= 1'b0;  zfen_q <= 1'b0;
    end else begin
      done_q <= done_nx;
      if (en) begin
        q_q <= q_nx;  r_q <= r_nx;  d_q <= d_nx;  src_q <= src_nx;
        cnt_q <= cnt_nx;  busy_q <= busy_nx;  err_q <= err_nx;
        zf_q <= zf_nx;  zfen_q <= zfen_nx;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign div_err   = err_q;
  assign zero_flag = zf_q;
  assign cnt_out   = cnt_q;
  assign quotient  = q_q;
  assign remainder = r_q[W-1:0];
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk
  import stepdiv_pkg::*;
#(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_op,
  input logic [CW-1:0] cnt_in,
  input logic          busy,
  input logic          done,
  input logic          div_err,
  input logic [W-1:0]  quotient,
  input logic [W-1:0]  remainder,
  input logic [W-1:0]  d_q
);
  logic live_step;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_step <= 1'b0;
    else if (cmd_valid && !busy)
      live_step <= (cmd_op == OP_STEP) && (cnt_in != '0) && (d_q != '0);
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);  // R10
  AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> ($stable(quotient) && $stable(remainder)));  // R5
  AST_OVERSHOOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_STEP && cnt_in == '0)
      |=> (done && $stable(quotient) && $stable(remainder)));  // R6
  AST_STEP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_STEP && cnt_in != '0 && d_q != '0)
      |=> busy);  // R7
  AST_STEP_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && live_step) |-> (remainder < d_q));  // R11
endmodule

bind stepdiv stepdiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cnt_in(cnt_in), .busy(busy), .done(done), .div_err(div_err),
  .quotient(quotient), .remainder(remainder), .d_q(d_q)
);

// File: tb/stepdiv_tb.sv
module stepdiv_tb;
  localparam int W = 64;
  localparam int CW = 7;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    {64'd100, 64'd7},
    {64'd7, 64'd100},
    {64'd0, 64'd5},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'd1},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
    {64'd123456789, 64'd1000},
    {64'h8000_0000_0000_0001, 64'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_op, cmd_zf_en;
  logic [W-1:0] src_word, div_in;
  logic [CW-1:0] cnt_in;
  logic busy, done, div_err, zero_flag;
  logic [CW-1:0] cnt_out;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepdiv #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_zf_en(cmd_zf_en), .src_word(src_word), .div_in(div_in),
    .cnt_in(cnt_in), .busy(busy), .done(done), .div_err(div_err),
    .zero_flag(zero_flag), .cnt_out(cnt_out), .quotient(quotient),
    .remainder(remainder)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic op, input logic [W-1:0] s, input logic [W-1:0] d,
                         input logic [CW-1:0] c, input logic z, output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; src_word = s; div_in = d; cnt_in = c; cmd_zf_en = z;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic full_div(input logic [W-1:0] n, input logic [W-1:0] d);
    logic [CW-1:0] c;
    int l;
    run_cmd(1'b0, '0, d, '0, 1'b0, l);
    c = CW'(W);
    for (int it = 0; it < 70 && c != '0; it++) begin
      run_cmd(1'b1, n, '0, c, 1'b1, l);
      c = cnt_out;
    end
    check("R11 quotient", quotient, n / d);
    check("R11 remainder", remainder, n % d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_zf_en = 1'b0;
    src_word = '0; div_in = '0; cnt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", W'(busy), '0);
    check("R1 done", W'(done), '0);
    check("R1 div_err", W'(div_err), '0);
    check("R1 zero_flag", W'(zero_flag), '0);
    check("R1 cnt_out", W'(cnt_out), '0);
    check("R1 quotient", quotient, '0);
    check("R1 remainder", remainder, '0);

    // table walk: full division against / and %
    for (int i = 0; i < NVEC; i++) full_div(VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // random operands
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] n, d;
      n = {$urandom, $urandom};
      d = {$urandom, $urandom} >> ($urandom % 64);
      if (i == 0) d = 1;
      if (i == 1) begin n = 64'd5; d = 64'hFFFF_0000_0000_0000; end
      if (d == '0) d = 1;
      full_div(n, d);
    end

    // R2 / R4 single aligned subtract
    run_cmd(1'b0, 64'd100, 64'd3, '0, 1'b0, lat);
    check("R2 latency", W'(lat), 64'd1);
    check("R2 div_err", W'(div_err), '0);
    check("R4 quotient 100/3", quotient, 64'd32);
    check("R4 remainder 100/3", remainder, 64'd4);
    run_cmd(1'b0, 64'd100, 64'd7, '0, 1'b0, lat);
    check("R4 backoff quotient", quotient, 64'd8);
    check("R4 backoff remainder", remainder, 64'd44);
    // R3 divisor larger than dividend
    run_cmd(1'b0, 64'd7, 64'd100, '0, 1'b0, lat);
    check("R3 quotient", quotient, 64'd0);
    check("R3 remainder", remainder, 64'd7);
    // R5 zero divisor
    run_cmd(1'b0, 64'd50, 64'd0, '0, 1'b0, lat);
    check("R5 div_err", W'(div_err), 64'd1);
    check("R5 quotient", quotient, 64'd0);
    check("R5 remainder", remainder, 64'd7);

    // R7 / R10 step latency, with a LOAD held while busy
    run_cmd(1'b0, 64'd0, 64'd4, '0, 1'b0, lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; src_word = 64'd7; cnt_in = 7'd3; cmd_zf_en = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk);
    cmd_op = 1'b0; src_word = 64'hFFFF; div_in = 64'd1;
    while (!done && lat < 300) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R7 step latency", W'(lat), 64'd5);
    check("R10 quotient after ignored LOAD", quotient, 64'd1);
    check("R10 remainder after ignored LOAD", remainder, 64'd3);
    check("R8 cnt_out", W'(cnt_out), 64'd0);
    check("R9 zero_flag set", W'(zero_flag), 64'd1);

    // R6 overshoot step, zero flag disabled
    run_cmd(1'b1, 64'hABCD, '0, 7'd0, 1'b0, lat);
    check("R6 latency", W'(lat), 64'd1);
    check("R6 quotient", quotient, 64'd1);
    check("R6 remainder", remainder, 64'd3);
    check("R6 cnt_out", W'(cnt_out), 64'd0);
    check("R9 zero_flag held", W'(zero_flag), 64'd1);

    // R8 early stop
    run_cmd(1'b0, 64'd0, 64'd1, '0, 1'b0, lat);
    run_cmd(1'b1, 64'h8000_0000_0000_0000, '0, 7'd64, 1'b1, lat);
    check("R8 latency", W'(lat), 64'd3);
    check("R8 cnt_out", W'(cnt_out), 64'd63);
    check("R8 quotient", quotient, 64'd1);
    check("R9 zero_flag cleared", W'(zero_flag), 64'd0);
    run_cmd(1'b1, 64'h8000_0000_0000_0000, '0, 7'd63, 1'b0, lat);
    check("R7 long step latency", W'(lat), 64'd65);
    check("R8 final cnt_out", W'(cnt_out), 64'd0);
    check("R9 zero_flag held low", W'(zero_flag), 64'd0);
    check("R11 quotient", quotient, 64'h8000_0000_0000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule